// File: doc/BRIEF.md
# Serial Display Command Receiver

This block is the write side of a segment LCD controller's serial port. A host sends frames over three wires: a chip enable, a serial clock and a data line. While chip enable is low, the block collects a device address, least significant bit first. If the last eight bits it collected equal 42h when chip enable rises, it shifts in a data frame on each rising serial-clock edge. When chip enable falls, it inspects the frame length, the fixed padding and the trailing four-bit direction code. It then commits the payload to one of four 150-bit display banks or to the packed control word. A frame that fails any of these tests is dropped whole.

All three serial inputs are sampled by the block's own clock through two register stages. The state machine has four states. ADDR collects address bits. DATA collects frame bits. SKIP waits out a frame addressed to another device. COMMIT spends one cycle writing the decoded frame. The named transitions are MATCH (ADDR to DATA, address hit at chip-enable rise), MISS (ADDR to SKIP, no hit), END (DATA to COMMIT, chip-enable fall), DONE (COMMIT to ADDR) and DROP (SKIP to ADDR, chip-enable fall). The control word supplies key-scan standby levels, general-purpose port levels, a contrast code with its enable, segment blanking, sleep and a two-bit display-technique select. The port levels are passed through unchanged whatever the sleep bit holds.

Top module: `slcd_cmd_rx`

## Requirements
- R1: After reset, `disp_bits` and every control output are zero.
- R2: During chip-enable low, each rising `scl` shifts `sdi` into the address, first bit as bit 0. A frame is accepted only if at least eight bits arrived in that low period and the last eight equal 8'h42. Otherwise the following frame changes nothing.
- R3: A display frame has exactly 160 bits, in this order: 150 payload bits, 6 zero pad bits, then the direction bits d3, d2, d1, d0. It requires d3=d2=0, and bank = {d1,d0}. Payload bit i goes to `disp_bits[bank*150+i]`. Other banks keep their contents.
- R4: A control frame has exactly 28 bits. Its 19 field bits arrive in this order: key-scan 1..6 (to `ks_level[0..5]`), port 1..4 (to `gp_port[0..3]`), contrast bits 0..3 (LSB first), contrast enable, segment blank, sleep, technique bit 1, technique bit 2 (`duty_sel[0]`, `duty_sel[1]`). Then come 5 zero pad bits, then the direction bits 0,1,0,0.
- R5: In an accepted control frame with a contrast code above 10, `contrast` keeps its old value while all other control fields update. Codes 0 to 10 are stored.
- R6: A frame whose length is neither 160 nor 28, whose pad bits are not all zero, or whose direction code does not fit its length leaves every output unchanged.
- R7: Outputs change only on the third clock edge after `ce` is first low, counting that edge as the first. Nothing changes while `ce` is high.
- R8: Data bits are taken on `scl` rising edges only. Changes of `sdi` while `scl` stays high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Serial chip enable |
| scl | input | 1 | Serial clock |
| sdi | input | 1 | Serial data |
| disp_bits | output | 600 | Four display banks; bank b bit i at b*150+i |
| ks_level | output | 6 | Key-scan standby levels |
| gp_port | output | 4 | General-purpose port levels |
| contrast | output | 4 | Contrast step, 0 to 10 |
| contrast_en | output | 1 | Contrast adjustment enable |
| seg_blank | output | 1 | Segment blanking (1 = segments off) |
| sleep_mode | output | 1 | Sleep request |
| duty_sel | output | 2 | Display technique select {bit 2, bit 1} |

## Verification
The assertions rely on three conditions for the serial inputs. The inputs are treated as slow relative to `clk`. Each level is held for at least two clocks. `ce` and `scl` never change in the same clock. Under these conditions every edge is seen exactly once, and no address bit can land in the data shift or the reverse. The stimulus keeps to this by holding `sdi` for two clocks before each `scl` rise and by keeping `scl` low for several clocks on either side of a `ce` transition. It still toggles `sdi` freely while `scl` is high.

// File: rtl/slcd_pkg.sv
package slcd_pkg;

    localparam int unsigned KS_N        = 6;
    localparam int unsigned GP_N        = 4;
    localparam int unsigned CT_W        = 4;
    localparam int unsigned CT_MAX      = 10;
    localparam int unsigned DT_W        = 2;
    localparam int unsigned CTRL_FIELDS = KS_N + GP_N + CT_W + 3 + DT_W;

    // receive sequencer states
    typedef enum logic [1:0] {
        S_ADDR   = 2'd0,
        S_DATA   = 2'd1,
        S_SKIP   = 2'd2,
        S_COMMIT = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic [KS_N-1:0] ks;
        logic [GP_N-1:0] gp;
        logic [CT_W-1:0] ct;
        logic            ctc;
        logic            sc;
        logic            sp;
        logic [DT_W-1:0] dt;
    } ctrl_t;

endpackage

// File: rtl/slcd_in_sync.sv
module slcd_in_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_i,
    input  logic cl_i,
    input  logic sd_i,
    output logic ce_lvl_o,
    output logic ce_rise_o,
    output logic ce_fall_o,
    output logic cl_rise_o,
    output logic sd_lvl_o
);

    logic [2:0] s1_q;
    logic [1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= {sd_i, cl_i, ce_i};
            s2_q <= s1_q[1:0];
        end
    end

    assign ce_lvl_o  = s1_q[0];
    assign ce_rise_o = s1_q[0] & ~s2_q[0];
    assign ce_fall_o = ~s1_q[0] & s2_q[0];
    assign cl_rise_o = s1_q[1] & ~s2_q[1];
    assign sd_lvl_o  = s1_q[2];

endmodule

// File: rtl/slcd_frame_fsm.sv
module slcd_frame_fsm
    import slcd_pkg::*;
#(
    parameter int unsigned            ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]      DEV_ADDR  = 8'h42,
    parameter int unsigned            BANKS     = 4,
    parameter int unsigned            BANK_BITS = 150,
    parameter int unsigned            DISP_PAD  = 6,
    parameter int unsigned            CTRL_PAD  = 5,
    parameter int unsigned            DIR_W     = 4,
    parameter logic [DIR_W-1:0]       CTRL_CODE = 4'b0100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_lvl,
    input  logic                 ce_rise,
    input  logic                 ce_fall,
    input  logic                 cl_rise,
    input  logic                 sd_lvl,
    output logic [BANKS-1:0]     bank_we_o,
    output logic [BANK_BITS-1:0] bank_data_o,
    output logic                 ctrl_we_o,
    output ctrl_t                ctrl_new_o
);

    localparam int unsigned SEL_W  = $clog2(BANKS);
    localparam int unsigned DLEN   = BANK_BITS + DISP_PAD + DIR_W;
    localparam int unsigned CLEN   = CTRL_FIELDS + CTRL_PAD + DIR_W;
    localparam int unsigned CNT_W  = $clog2(DLEN + 2);
    localparam int unsigned ACNT_W = $clog2(ADDR_W + 1);
    localparam logic [CNT_W-1:0]  CNT_SAT   = CNT_W'(DLEN + 1);
    localparam logic [CNT_W-1:0]  CNT_DISP  = CNT_W'(DLEN);
    localparam logic [CNT_W-1:0]  CNT_CTRL  = CNT_W'(CLEN);
    localparam logic [ACNT_W-1:0] ADDR_FULL = ACNT_W'(ADDR_W);
    localparam int unsigned O_GP  = KS_N;
    localparam int unsigned O_CT  = O_GP + GP_N;
    localparam int unsigned O_CTC = O_CT + CT_W;
    localparam int unsigned O_DT  = O_CTC + 3;

    rx_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_sr;
    logic [ACNT_W-1:0] addr_cnt;
    logic [DLEN-1:0]   sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              addr_hit;
    logic [DIR_W-1:0]  dir;
    logic              disp_hit;
    logic              ctrl_hit;
    logic [CTRL_FIELDS-1:0] fld;

    assign addr_hit = (addr_cnt == ADDR_FULL) && (addr_sr == DEV_ADDR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_ADDR;
        else        state_q <= state_d;
    end

    // transitions: MATCH, MISS, END, DONE, DROP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ADDR:   if (ce_rise) state_d = addr_hit ? S_DATA : S_SKIP;
            S_DATA:   if (ce_fall) state_d = S_COMMIT;
            S_SKIP:   if (ce_fall) state_d = S_ADDR;
            S_COMMIT: state_d = S_ADDR;
            default:  state_d = S_ADDR;
        endcase
    end

    // shift and count registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_sr  <= '0;
            addr_cnt <= '0;
            sh_q     <= '0;
            cnt_q    <= '0;
        end else begin
            unique case (state_q)
                S_ADDR: begin
                    if (ce_rise) begin
                        sh_q  <= '0;
                        cnt_q <= '0;
                    end else if (cl_rise && !ce_lvl) begin
                        addr_sr <= {sd_lvl, addr_sr[ADDR_W-1:1]};
                        if (addr_cnt != ADDR_FULL) addr_cnt <= addr_cnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (cl_rise && ce_lvl) begin
                        sh_q <= {sh_q[DLEN-2:0], sd_lvl};
                        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_SKIP: begin
                    if (ce_fall) addr_cnt <= '0;
                end
                S_COMMIT: begin
                    addr_cnt <= '0;
                end
                default: ;
            endcase
        end
    end

    // frame decode, live only in COMMIT
    always_comb begin
        dir      = sh_q[DIR_W-1:0];
        disp_hit = (state_q == S_COMMIT) && (cnt_q == CNT_DISP)
                   && (dir[DIR_W-1:SEL_W] == '0)
                   && (sh_q[DIR_W+DISP_PAD-1:DIR_W] == '0);
        ctrl_hit = (state_q == S_COMMIT) && (cnt_q == CNT_CTRL)
                   && (dir == CTRL_CODE)
                   && (sh_q[DIR_W+CTRL_PAD-1:DIR_W] == '0);
        for (int b = 0; b < BANKS; b++) begin
            bank_we_o[b] = disp_hit && (dir[SEL_W-1:0] == SEL_W'(b));
        end
        ctrl_we_o = ctrl_hit;
    end

    // first received payload bit lands at index 0
    for (genvar i = 0; i < BANK_BITS; i++) begin : g_bank_bit
        assign bank_data_o[i] = sh_q[DLEN-1-i];
    end

    for (genvar k = 0; k < CTRL_FIELDS; k++) begin : g_ctrl_bit
        assign fld[k] = sh_q[CLEN-1-k];
    end

    assign ctrl_new_o.ks  = fld[KS_N-1:0];
    assign ctrl_new_o.gp  = fld[O_GP +: GP_N];
    assign ctrl_new_o.ct  = fld[O_CT +: CT_W];
    assign ctrl_new_o.ctc = fld[O_CTC];
    assign ctrl_new_o.sc  = fld[O_CTC+1];
    assign ctrl_new_o.sp  = fld[O_CTC+2];
    assign ctrl_new_o.dt  = fld[O_DT +: DT_W];

    p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_we_o, bank_we_o}));

    p_match_before_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA) |-> ((addr_cnt == ADDR_FULL) && (addr_sr == DEV_ADDR)));

    p_commit_follows_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COMMIT) |-> ($past(state_q) == S_DATA));

    p_count_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_SAT);

endmodule

// File: rtl/slcd_store.sv
module slcd_store
    import slcd_pkg::*;
#(
    parameter int unsigned BANKS     = 4,
    parameter int unsigned BANK_BITS = 150
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [BANKS-1:0]           bank_we,
    input  logic [BANK_BITS-1:0]       bank_data,
    input  logic                       ctrl_we,
    input  ctrl_t                      ctrl_new,
    output logic [BANKS*BANK_BITS-1:0] disp_o,
    output ctrl_t                      ctrl_o
);

    localparam logic [CT_W-1:0] CT_LIMIT = CT_W'(CT_MAX);

    ctrl_t ctrl_q;
    logic  ct_ok;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [BANK_BITS-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          q <= '0;
            else if (bank_we[b]) q <= bank_data;
        end
        assign disp_o[b*BANK_BITS +: BANK_BITS] = q;
    end

    assign ct_ok = (ctrl_new.ct <= CT_LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q.ks  <= ctrl_new.ks;
            ctrl_q.gp  <= ctrl_new.gp;
            ctrl_q.ctc <= ctrl_new.ctc;
            ctrl_q.sc  <= ctrl_new.sc;
            ctrl_q.sp  <= ctrl_new.sp;
            ctrl_q.dt  <= ctrl_new.dt;
            if (ct_ok) ctrl_q.ct <= ctrl_new.ct;
        end
    end

    assign ctrl_o = ctrl_q;

    p_contrast_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.ct <= CT_LIMIT);

    p_reject_keeps_ct_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && (ctrl_new.ct > CT_LIMIT)) |=> $stable(ctrl_q.ct));

    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_we && (bank_we == '0)) |=> ($stable(disp_o) && $stable(ctrl_q)));

endmodule

// File: rtl/slcd_cmd_rx.sv
module slcd_cmd_rx
    import slcd_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR  = 8'h42,
    parameter int unsigned       BANKS     = 4,
    parameter int unsigned       BANK_BITS = 150,
    parameter int unsigned       DISP_PAD  = 6,
    parameter int unsigned       CTRL_PAD  = 5,
    parameter int unsigned       DIR_W     = 4,
    parameter logic [DIR_W-1:0]  CTRL_CODE = 4'b0100
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce,
    input  logic                       scl,
    input  logic                       sdi,
    output logic [BANKS*BANK_BITS-1:0] disp_bits,
    output logic [KS_N-1:0]            ks_level,
    output logic [GP_N-1:0]            gp_port,
    output logic [CT_W-1:0]            contrast,
    output logic                       contrast_en,
    output logic                       seg_blank,
    output logic                       sleep_mode,
    output logic [DT_W-1:0]            duty_sel
);

    logic                 ce_lvl, ce_rise, ce_fall, cl_rise, sd_lvl;
    logic [BANKS-1:0]     bank_we;
    logic [BANK_BITS-1:0] bank_data;
    logic                 ctrl_we;
    ctrl_t                ctrl_new;
    ctrl_t                ctrl_cur;

    slcd_in_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_i      (ce),
        .cl_i      (scl),
        .sd_i      (sdi),
        .ce_lvl_o  (ce_lvl),
        .ce_rise_o (ce_rise),
        .ce_fall_o (ce_fall),
        .cl_rise_o (cl_rise),
        .sd_lvl_o  (sd_lvl)
    );

    slcd_frame_fsm #(
        .ADDR_W    (ADDR_W),
        .DEV_ADDR  (DEV_ADDR),
        .BANKS     (BANKS),
        .BANK_BITS (BANK_BITS),
        .DISP_PAD  (DISP_PAD),
        .CTRL_PAD  (CTRL_PAD),
        .DIR_W     (DIR_W),
        .CTRL_CODE (CTRL_CODE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_lvl      (ce_lvl),
        .ce_rise     (ce_rise),
        .ce_fall     (ce_fall),
        .cl_rise     (cl_rise),
        .sd_lvl      (sd_lvl),
        .bank_we_o   (bank_we),
        .bank_data_o (bank_data),
        .ctrl_we_o   (ctrl_we),
        .ctrl_new_o  (ctrl_new)
    );

    slcd_store #(
        .BANKS     (BANKS),
        .BANK_BITS (BANK_BITS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_we   (bank_we),
        .bank_data (bank_data),
        .ctrl_we   (ctrl_we),
        .ctrl_new  (ctrl_new),
        .disp_o    (disp_bits),
        .ctrl_o    (ctrl_cur)
    );

    assign ks_level    = ctrl_cur.ks;
    assign gp_port     = ctrl_cur.gp;
    assign contrast    = ctrl_cur.ct;
    assign contrast_en = ctrl_cur.ctc;
    assign seg_blank   = ctrl_cur.sc;
    assign sleep_mode  = ctrl_cur.sp;
    assign duty_sel    = ctrl_cur.dt;

endmodule

// File: tb/tb_slcd_cmd_rx.sv
module tb_slcd_cmd_rx;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n, ce, scl, sdi;
    logic [599:0] disp_bits;
    logic [5:0]   ks_level;
    logic [3:0]   gp_port;
    logic [3:0]   contrast;
    logic         contrast_en, seg_blank, sleep_mode;
    logic [1:0]   duty_sel;

    slcd_cmd_rx dut (
        .clk (clk), .rst_n (rst_n), .ce (ce), .scl (scl), .sdi (sdi),
        .disp_bits (disp_bits), .ks_level (ks_level), .gp_port (gp_port),
        .contrast (contrast), .contrast_en (contrast_en), .seg_blank (seg_blank),
        .sleep_mode (sleep_mode), .duty_sel (duty_sel)
    );

    int n_chk = 0;
    int n_err = 0;
    bit live  = 1'b0;

    // reference state
    logic [599:0] e_disp = '0;
    logic [5:0]   e_ks   = '0;
    logic [3:0]   e_gp   = '0;
    logic [3:0]   e_ct   = '0;
    logic         e_ctc  = 1'b0, e_sc = 1'b0, e_sp = 1'b0;
    logic [1:0]   e_dt   = '0;

    bit addr_q[$];
    bit data_q[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [599:0] act, input logic [599:0] ev);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, ev);
        end
    endtask

    task automatic check_all(input string tag);
        chk(disp_bits == e_disp, tag, "disp_bits", disp_bits, e_disp);
        chk(ks_level == e_ks, tag, "ks_level", 600'(ks_level), 600'(e_ks));
        chk(gp_port == e_gp, tag, "gp_port", 600'(gp_port), 600'(e_gp));
        chk(contrast == e_ct, tag, "contrast", 600'(contrast), 600'(e_ct));
        chk({contrast_en, seg_blank, sleep_mode, duty_sel} == {e_ctc, e_sc, e_sp, e_dt},
            tag, "flags", 600'({contrast_en, seg_blank, sleep_mode, duty_sel}),
            600'({e_ctc, e_sc, e_sp, e_dt}));
    endtask

    // per-clock comparison against the reference (R3 R4 R5 R7)
    always @(negedge clk) begin
        if (live) check_all("R7");
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input bit b, input bit noisy);
        sdi = b;
        hold(2);
        scl = 1'b1;
        hold(1);
        if (noisy) begin
            sdi = ~b;
            hold(1);
            sdi = b;
        end else begin
            hold(1);
        end
        hold(2);
        scl = 1'b0;
        hold(1);
    endtask

    function automatic bit pat(input int s, input int i);
        return ((i * (2 * s + 1) + (i >> 2) * s) % 5) < 2;
    endfunction

    task automatic mk_addr(input logic [7:0] a, input int lead, input bit drop_first);
        addr_q.delete();
        for (int j = 0; j < lead; j++) addr_q.push_back(1'b1);
        for (int j = 0; j < 8; j++) addr_q.push_back(a[j]);
        if (drop_first) void'(addr_q.pop_front());
    endtask

    task automatic mk_disp(input int seed, input logic [3:0] code, input int adj, input bit padbit);
        data_q.delete();
        for (int i = 0; i < 150; i++) data_q.push_back(pat(seed, i));
        for (int j = 0; j < 6; j++) data_q.push_back(j == 2 ? padbit : 1'b0);
        for (int j = 3; j >= 0; j--) data_q.push_back(code[j]);
        if (adj < 0) void'(data_q.pop_front());
        if (adj > 0) data_q.push_front(1'b0);
    endtask

    task automatic mk_ctrl(input logic [5:0] ks, input logic [3:0] gp, input logic [3:0] ct,
                           input bit ctc, input bit sc, input bit sp, input logic [1:0] dt);
        data_q.delete();
        for (int j = 0; j < 6; j++) data_q.push_back(ks[j]);
        for (int j = 0; j < 4; j++) data_q.push_back(gp[j]);
        for (int j = 0; j < 4; j++) data_q.push_back(ct[j]);
        data_q.push_back(ctc);
        data_q.push_back(sc);
        data_q.push_back(sp);
        data_q.push_back(dt[0]);
        data_q.push_back(dt[1]);
        for (int j = 0; j < 5; j++) data_q.push_back(1'b0);
        data_q.push_back(1'b0);
        data_q.push_back(1'b1);
        data_q.push_back(1'b0);
        data_q.push_back(1'b0);
    endtask

    // reference decision from the requirement text
    task automatic model_apply();
        int na = addr_q.size();
        int n  = data_q.size();
        int av = 0;
        bit ok;
        if (na < 8) return;
        for (int j = 0; j < 8; j++) av += int'(addr_q[na - 8 + j]) << j;
        if (av != 'h42) return;
        if (n == 160) begin
            ok = 1'b1;
            for (int j = 150; j < 158; j++) if (data_q[j]) ok = 1'b0;
            if (ok) begin
                int bank = int'(data_q[158]) * 2 + int'(data_q[159]);
                for (int i = 0; i < 150; i++) e_disp[bank * 150 + i] = data_q[i];
            end
        end else if (n == 28) begin
            ok = 1'b1;
            for (int j = 19; j < 24; j++) if (data_q[j]) ok = 1'b0;
            if (data_q[24] || !data_q[25] || data_q[26] || data_q[27]) ok = 1'b0;
            if (ok) begin
                int ctv = 0;
                for (int j = 0; j < 6; j++) e_ks[j] = data_q[j];
                for (int j = 0; j < 4; j++) e_gp[j] = data_q[6 + j];
                for (int j = 0; j < 4; j++) ctv += int'(data_q[10 + j]) << j;
                if (ctv <= 10) e_ct = 4'(ctv);
                e_ctc = data_q[14];
                e_sc  = data_q[15];
                e_sp  = data_q[16];
                e_dt  = {data_q[18], data_q[17]};
            end
        end
    endtask

    task automatic send(input bit noisy, input string tag);
        foreach (addr_q[i]) put_bit(addr_q[i], 1'b0);
        hold(2);
        ce = 1'b1;
        hold(3);
        foreach (data_q[i]) put_bit(data_q[i], noisy);
        hold(3);
        check_all("R7");
        ce = 1'b0;
        repeat (3) @(posedge clk);
        model_apply();
        hold(3);
        check_all(tag);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0; ce = 1'b0; scl = 1'b0; sdi = 1'b0;
        hold(4);
        rst_n = 1'b1;
        hold(2);
        check_all("R1");
        live = 1'b1;

        // R3: each bank in turn
        mk_addr(8'h42, 0, 1'b0); mk_disp(1, 4'b0000, 0, 1'b0); send(1'b0, "R3");
        mk_addr(8'h42, 0, 1'b0); mk_disp(2, 4'b0010, 0, 1'b0); send(1'b0, "R3");
        mk_addr(8'h42, 0, 1'b0); mk_disp(3, 4'b0001, 0, 1'b0); send(1'b0, "R3");
        mk_addr(8'h42, 0, 1'b0); mk_disp(4, 4'b0011, 0, 1'b0); send(1'b0, "R3");

        // R4: control fields
        mk_addr(8'h42, 0, 1'b0); mk_ctrl(6'b101101, 4'b0110, 4'd7, 1, 0, 1, 2'b10); send(1'b0, "R4");
        // R5: boundary accepted, above range rejected
        mk_addr(8'h42, 0, 1'b0); mk_ctrl(6'b010011, 4'b1001, 4'd10, 0, 1, 0, 2'b01); send(1'b0, "R5");
        mk_addr(8'h42, 0, 1'b0); mk_ctrl(6'b111000, 4'b0011, 4'd11, 1, 0, 1, 2'b00); send(1'b0, "R5");
        mk_addr(8'h42, 0, 1'b0); mk_ctrl(6'b000111, 4'b1100, 4'd15, 0, 1, 1, 2'b11); send(1'b0, "R5");
        mk_addr(8'h42, 0, 1'b0); mk_ctrl(6'b100001, 4'b0101, 4'd0, 1, 1, 0, 2'b01); send(1'b0, "R4");

        // R2: address handling
        mk_addr(8'h43, 0, 1'b0); mk_disp(9, 4'b0000, 0, 1'b0); send(1'b0, "R2");
        mk_addr(8'h42, 1, 1'b0); mk_disp(5, 4'b0001, 0, 1'b0); send(1'b0, "R2");
        mk_addr(8'h42, 0, 1'b1); mk_disp(7, 4'b0010, 0, 1'b0); send(1'b0, "R2");
        mk_addr(8'h02, 0, 1'b0); mk_ctrl(6'b111111, 4'b1111, 4'd3, 1, 1, 1, 2'b11); send(1'b0, "R2");

        // R6: malformed frames
        mk_addr(8'h42, 0, 1'b0); mk_disp(8, 4'b0000, -1, 1'b0); send(1'b0, "R6");
        mk_addr(8'h42, 0, 1'b0); mk_disp(8, 4'b0000, 1, 1'b0); send(1'b0, "R6");
        mk_addr(8'h42, 0, 1'b0); mk_disp(8, 4'b1001, 0, 1'b0); send(1'b0, "R6");
        mk_addr(8'h42, 0, 1'b0); mk_disp(8, 4'b0100, 0, 1'b0); send(1'b0, "R6");
        mk_addr(8'h42, 0, 1'b0); mk_disp(8, 4'b0001, 0, 1'b1); send(1'b0, "R6");

        // R8: data noise while scl is high
        mk_addr(8'h42, 0, 1'b0); mk_disp(6, 4'b0011, 0, 1'b0); send(1'b1, "R8");
        mk_addr(8'h42, 0, 1'b0); mk_ctrl(6'b011010, 4'b1010, 4'd9, 1, 0, 0, 2'b10); send(1'b1, "R8");

        live = 1'b0;
        hold(2);
        report();
        $finish;
    end

endmodule